// File: doc/BRIEF.md
# Wraparound Shift Permutation Network

This block moves one data word per processing element to a neighbouring element in a single clock step. The elements form a square array of side `SIDE`, which gives `N = SIDE*SIDE` elements numbered 0 to N-1 in row-major order. A two-bit select picks one of four shifts: one place forward, one place back, one row forward, or one row back. Each source element's word lands at the element whose index is the source index plus the shift, taken modulo N.

Horizontal shifts do not wrap inside a row. They run along the whole linear index, so the last element of one row feeds the first element of the next row, and element N-1 feeds element 0. Vertical shifts move a word by `SIDE` places modulo N, so each column forms its own closed ring. A strobe on `in_valid` captures all N words at once. The permuted words appear on the outputs one clock later, marked by `out_valid`. Between strobes the outputs keep their last value.

Top module: `illiac_shift_net`

## Requirements
- R1: While `rst_n` is low and after it rises, `out_valid` is 0 and every output word is 0 until the first strobe is taken.
- R2: `out_valid` is 1 in exactly the cycle after a clock edge at which `in_valid` was 1, and is 0 otherwise.
- R3: Select code 2'b00 (shift +1): output word (i+1) mod N receives input word i. A single ring of order N results.
- R4: Select code 2'b01 (shift -1): output word (i-1) mod N receives input word i.
- R5: Select code 2'b10 (shift +SIDE): output word (i+SIDE) mod N receives input word i. Each column forms a ring of order SIDE.
- R6: Select code 2'b11 (shift -SIDE): output word (i-SIDE) mod N receives input word i. For example, with SIDE = 4 the data moves 12→8→4→0→12.
- R7: Horizontal shifts wrap across rows and do not wrap within a row. Under +1, output SIDE receives input SIDE-1 and output 0 receives input N-1. Under -1, output SIDE-1 receives input SIDE.
- R8: At a clock edge where `in_valid` is 0, the outputs keep their previous value, whatever is present on `data_in` and `func_sel`.
- R9: Each transfer is a bijection. When all input words are distinct, every input word appears on exactly one output and no output is left unwritten.
- R10: Output word k occupies bits [k*W +: W] of `data_out`, and input word i occupies bits [i*W +: W] of `data_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: capture and permute `data_in` this edge |
| func_sel | input | 2 | Shift select: 00 +1, 01 -1, 10 +SIDE, 11 -SIDE |
| data_in | input | N*W | Input words, word i at bits [i*W +: W] |
| out_valid | output | 1 | Marks the cycle after a strobe |
| data_out | output | N*W | Permuted words, word k at bits [k*W +: W] |

## Verification
The hardest case to reach is the seam between rows under the horizontal shifts. A design that rotates inside each row would give correct results for 12 of the 16 destinations. It would go wrong only where a word has to cross into the next row. The bench therefore loads every element with a distinct word, runs all four selects over several such patterns, and compares all destinations against an index computed arithmetically. That comparison catches any misrouted seam, and a separate bijection count catches any duplicate or missing word. The hold behaviour is checked by changing both the data and the select while the strobe is low and then reading the unchanged outputs.

// File: rtl/illiac_shift_net.sv
module illiac_shift_net #(
  parameter int SIDE = 4,
  parameter int W    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             func_sel,
  input  logic [SIDE*SIDE*W-1:0] data_in,
  output logic                   out_valid,
  output logic [SIDE*SIDE*W-1:0] data_out
);
  localparam int N = SIDE * SIDE;

  logic [N*W-1:0] routed;

  genvar d;
  generate
    for (d = 0; d < N; d++) begin : g_dst
      localparam int SRC_FWD  = (d + N - 1) % N;
      localparam int SRC_BACK = (d + 1) % N;
      localparam int SRC_DOWN = (d + N - SIDE) % N;
      localparam int SRC_UP   = (d + SIDE) % N;
      always_comb begin
        case (func_sel)
          2'b00:   routed[d*W +: W] = data_in[SRC_FWD*W  +: W];
          2'b01:   routed[d*W +: W] = data_in[SRC_BACK*W +: W];
          2'b10:   routed[d*W +: W] = data_in[SRC_DOWN*W +: W];
          default: routed[d*W +: W] = data_in[SRC_UP*W   +: W];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      data_out  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) data_out <= routed;
    end
  end

  // R2
  vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2
  vld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(data_out));
  // R3 R7
  fwd_seam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func_sel == 2'b00) |=> data_out[0 +: W] == $past(data_in[(N-1)*W +: W]));
  // R4 R7
  back_seam_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func_sel == 2'b01) |=> data_out[(SIDE-1)*W +: W] == $past(data_in[SIDE*W +: W]));
  // R5
  down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func_sel == 2'b10) |=> data_out[SIDE*W +: W] == $past(data_in[0 +: W]));
  // R6
  up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && func_sel == 2'b11) |=> data_out[0 +: W] == $past(data_in[SIDE*W +: W]));
endmodule

// File: tb/illiac_shift_net_tb.sv
module illiac_shift_net_tb;
  localparam int SIDE = 4;
  localparam int W    = 16;
  localparam int N    = SIDE * SIDE;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [1:0]     func_sel = 2'b00;
  logic [N*W-1:0] data_in = '0;
  logic           out_valid;
  logic [N*W-1:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  illiac_shift_net #(.SIDE(SIDE), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .func_sel(func_sel),
    .data_in(data_in), .out_valid(out_valid), .data_out(data_out)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int shift_of(input logic [1:0] s);
    case (s)
      2'b00:   return 1;
      2'b01:   return N - 1;
      2'b10:   return SIDE;
      default: return N - SIDE;
    endcase
  endfunction

  function automatic logic [W-1:0] word_of(input int pat, input int i);
    case (pat)
      0:       return W'(16'h0100 + i);
      1:       return W'(16'hA5C3 ^ (i * 16'h1357));
      2:       return W'(16'hFFFF - i * 16'h0101);
      default: return W'((i * 16'h2B) + 16'h7000);
    endcase
  endfunction

  task automatic run(input logic [1:0] s, input int pat);
    logic [N*W-1:0] expv;
    logic [N*W-1:0] snap;
    int sh;
    string tag;
    sh = shift_of(s);
    case (s)
      2'b00:   tag = "R3";
      2'b01:   tag = "R4";
      2'b10:   tag = "R5";
      default: tag = "R6";
    endcase
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      data_in[i*W +: W] = word_of(pat, i);
      expv[((i + sh) % N)*W +: W] = word_of(pat, i);
    end
    func_sel = s;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2 valid after strobe", longint'(out_valid), 1);
    for (int k = 0; k < N; k++)
      check(data_out[k*W +: W] == expv[k*W +: W], tag,
            longint'(data_out[k*W +: W]), longint'(expv[k*W +: W]));
    for (int i = 0; i < N; i++) begin
      int hits = 0;
      for (int k = 0; k < N; k++)
        if (data_out[k*W +: W] == word_of(pat, i)) hits++;
      check(hits == 1, "R9 bijection", hits, 1);
    end
    if (s == 2'b00) begin
      check(data_out[SIDE*W +: W] == word_of(pat, SIDE-1), "R7 row seam +1",
            longint'(data_out[SIDE*W +: W]), longint'(word_of(pat, SIDE-1)));
      check(data_out[0 +: W] == word_of(pat, N-1), "R7 end wrap +1",
            longint'(data_out[0 +: W]), longint'(word_of(pat, N-1)));
    end
    if (s == 2'b01)
      check(data_out[(SIDE-1)*W +: W] == word_of(pat, SIDE), "R7 row seam -1",
            longint'(data_out[(SIDE-1)*W +: W]), longint'(word_of(pat, SIDE)));
    snap = data_out;
    data_in = ~data_in;
    func_sel = ~s;
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid drops", longint'(out_valid), 0);
    check(data_out == snap, "R8 hold while idle", longint'(data_out[63:0]), longint'(snap[63:0]));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 reset valid", longint'(out_valid), 0);
    check(data_out == '0, "R1 reset data", longint'(data_out[63:0]), 0);
    rst_n = 1'b1;
    @(negedge clk);
    data_in = {N*W{1'b1}};
    @(negedge clk);
    check(data_out == '0 && out_valid == 1'b0, "R1 idle after reset",
          longint'(data_out[63:0]), 0);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 4; s++)
        run(2'(s), p);
    check(N*W == $bits(data_out), "R10 packing width", $bits(data_out), N*W);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule